// File: doc/BRIEF.md
# USB Host Schedule Link Walker

This block follows the linked list of transfer descriptors (TDs) and queue heads (QHs) that a USB host controller works through in one frame. A frame-start strobe supplies the first link word. The walker then reads link words from memory through a single-outstanding read port and decodes each one. It decides whether the next item is a TD or a QH, whether a queue is being entered or left, and whether the frame's schedule has ended. It hands every TD it reaches to a downstream executor as an address and waits for the executor's done strobe before it reads that TD's own link.

A QH occupies two words. The horizontal link at offset 0 leads onward past the queue. The element link at offset 4 leads into it. Inside a queue, each TD's link chooses between two orderings. Depth-first stays in the queue. Breadth-first leaves for the QH's horizontal link after a single TD. The terminate bit ends the queue when the walker is inside one, and ends the frame when it is not. A link word with its reserved bit set is a consistency failure. The walker then stops for good and raises an interrupt that nothing inside the block can mask.

Top module: `sched_link_walker`

## Requirements
- R1: After reset, `halted`, `irq`, `mem_rd_req`, `td_start` and `frame_done` are all low.
- R2: A link word carries the next item's address in bits 31:4. Bit 3 is reserved and must be 0. Bit 2 is the queue ordering bit (1 = depth-first, 0 = breadth-first). Bit 1 is the item kind (1 = QH, 0 = TD). Bit 0 is terminate. The item address is the link word with bits 3:0 cleared. On a `frame_start` pulse while idle, the walker decodes `frame_ptr` as such a link word.
- R3: For a TD, the walker drives `td_start` for one cycle with `td_addr` set to the 16-byte-aligned TD address. It issues no memory read until `td_done` arrives. It then reads the TD's link word at `td_addr`.
- R4: For a QH, the walker reads the horizontal link at the QH address and then the element link at QH address + 4. It then enters the queue, taking the element link as the next link.
- R5: Outside a queue, a link with terminate set ends the walk with a one-cycle `frame_done` pulse and a return to idle. A TD's ordering bit has no effect outside a queue.
- R6: Inside a queue, a terminate bit on the element link or on a TD's link leaves the queue and continues with the QH's horizontal link.
- R7: Inside a queue, a TD whose link has ordering bit 0 is followed by the QH's horizontal link. The remaining TDs of that queue are not handed off in this frame.
- R8: Inside a queue, a TD whose link has ordering bit 1 is followed by its own link, and the walker stays in the queue.
- R9: A reserved bit set in `frame_ptr` or in any fetched link word raises `halted` and `irq`. Both stay high until reset, and the walker then issues no reads and no TD hand-offs, and ignores `frame_start`.
- R10: At most one memory read is outstanding at a time. `mem_rd_req` is a one-cycle pulse, and `mem_rd_addr` is a byte address with bits 1:0 zero. A walk reads exactly one word per TD link and two words per QH.
- R11: A `frame_start` pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that begins a frame's walk |
| frame_ptr | input | 32 | First link word of the frame |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the requested 32-bit word |
| mem_rd_data | input | 32 | Read response data |
| mem_rd_valid | input | 1 | Read response strobe |
| td_start | output | 1 | One-cycle strobe handing a TD to the executor |
| td_addr | output | 32 | Address of the TD being handed off |
| td_done | input | 1 | Executor finished the current TD |
| frame_done | output | 1 | One-cycle pulse at the end of the frame's schedule |
| halted | output | 1 | Consistency failure seen; held until reset |
| irq | output | 1 | Unmaskable interrupt, held with `halted` |

## Verification
The walker is tried on several schedule shapes. A flat TD chain with stray ordering bits shows that the ordering bit is ignored outside a queue. A queue whose first TD selects breadth-first is compared with the same queue selecting depth-first, so the two give different TD sequences and read counts. A QH with an empty element link and a terminating `frame_ptr` separate queue exit from frame end. A reserved bit placed in a TD's link and then in `frame_ptr` shows where the halt takes effect and that it survives a later strobe. A second strobe during a running walk must leave the TD sequence unchanged.

// File: rtl/sched_walk_pkg.sv
// Shared constants and types for the schedule link walker.
// Assumes 32-bit link words and items aligned to 16 bytes.
package sched_walk_pkg;
    localparam int LINK_W     = 32;
    localparam int BIT_TERM   = 0;
    localparam int BIT_QH     = 1;
    localparam int BIT_DEPTH  = 2;
    localparam int BIT_RSV    = 3;
    localparam int ITEM_ALIGN = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DECODE, ST_EXEC, ST_WAIT, ST_HALT
    } walk_state_e;

    typedef enum logic [1:0] {
        FK_QH_HORIZ, FK_QH_ELEM, FK_TD_LINK
    } fetch_kind_e;

    typedef struct packed {
        logic [LINK_W-1:0] addr;
        logic              rsv;
        logic              is_qh;
        logic              term;
    } link_t;
endpackage

// File: rtl/sched_link_decode.sv
// Splits a link word into item address and control bits.
// Purely combinational; the ordering bit is read by the controller
// directly from fetched data, where it matters.
module sched_link_decode
    import sched_walk_pkg::*;
(
    input  logic [LINK_W-1:0] word,
    output link_t             fields
);
    // Field extraction
    always_comb begin
        fields.addr  = {word[LINK_W-1:ITEM_ALIGN], {ITEM_ALIGN{1'b0}}};
        fields.rsv   = word[BIT_RSV];
        fields.is_qh = word[BIT_QH];
        fields.term  = word[BIT_TERM];
    end
endmodule

// File: rtl/sched_rd_port.sv
// Single-outstanding memory read port.
// Assumes the controller issues a new read only after the previous
// one has completed; responses without a pending read are dropped.
module sched_rd_port
    import sched_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [LINK_W-1:0] issue_addr,
    output logic              done,
    output logic [LINK_W-1:0] data,
    output logic              mem_rd_req,
    output logic [LINK_W-1:0] mem_rd_addr,
    input  logic [LINK_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid
);
    logic pend;

    // Request pulse, address hold and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
            pend        <= 1'b0;
            done        <= 1'b0;
            data        <= '0;
        end else begin
            mem_rd_req <= issue;
            done       <= 1'b0;
            if (issue) begin
                mem_rd_addr <= issue_addr;
                pend        <= 1'b1;
            end else if (pend && mem_rd_valid) begin
                pend <= 1'b0;
                done <= 1'b1;
                data <= mem_rd_data;
            end
        end
    end
endmodule

// File: rtl/sched_walk_ctrl.sv
// Walk sequencer: decides the next fetch from the decoded current link,
// tracks queue context, hands TDs to the executor and latches the halt.
// Assumes rd_done/rd_data come from sched_rd_port and cur_f is the
// decode of cur_link.
module sched_walk_ctrl
    import sched_walk_pkg::*;
#(
    parameter int QH_ELEM_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [LINK_W-1:0] frame_ptr,
    output logic [LINK_W-1:0] cur_link,
    input  link_t             cur_f,
    output logic              rd_issue,
    output logic [LINK_W-1:0] rd_addr,
    input  logic              rd_done,
    input  logic [LINK_W-1:0] rd_data,
    output logic              td_start,
    output logic [LINK_W-1:0] td_addr,
    input  logic              td_done,
    output logic              frame_done,
    output logic              halted,
    output logic              irq
);
    localparam logic [LINK_W-1:0] ELEM_OFS = LINK_W'(QH_ELEM_OFFSET);

    walk_state_e       state;
    fetch_kind_e       kind;
    logic [LINK_W-1:0] horiz_q;
    logic [LINK_W-1:0] qh_addr_q;
    logic              in_q;
    logic              rsp_rsv;
    logic              rsp_depth;

    assign rsp_rsv   = rd_data[BIT_RSV];
    assign rsp_depth = rd_data[BIT_DEPTH];

    // Read issue: QH word 0 on decode, TD link after done, QH word 1 after word 0
    always_comb begin
        rd_issue = 1'b0;
        rd_addr  = '0;
        case (state)
            ST_DECODE: if (!cur_f.rsv && !cur_f.term && cur_f.is_qh) begin
                rd_issue = 1'b1;
                rd_addr  = cur_f.addr;
            end
            ST_EXEC: if (td_done) begin
                rd_issue = 1'b1;
                rd_addr  = td_addr;
            end
            ST_WAIT: if (rd_done && !rsp_rsv && kind == FK_QH_HORIZ) begin
                rd_issue = 1'b1;
                rd_addr  = qh_addr_q + ELEM_OFS;
            end
            default: ;
        endcase
    end

    // Walk state, queue context, strobes and sticky halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= FK_TD_LINK;
            cur_link   <= '0;
            horiz_q    <= '0;
            qh_addr_q  <= '0;
            td_addr    <= '0;
            in_q       <= 1'b0;
            td_start   <= 1'b0;
            frame_done <= 1'b0;
            halted     <= 1'b0;
            irq        <= 1'b0;
        end else begin
            td_start   <= 1'b0;
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: if (frame_start) begin
                    cur_link <= frame_ptr;
                    in_q     <= 1'b0;
                    state    <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (cur_f.rsv) begin
                        halted <= 1'b1;
                        irq    <= 1'b1;
                        state  <= ST_HALT;
                    end else if (cur_f.term) begin
                        if (in_q) begin
                            cur_link <= horiz_q;
                            in_q     <= 1'b0;
                        end else begin
                            frame_done <= 1'b1;
                            state      <= ST_IDLE;
                        end
                    end else if (cur_f.is_qh) begin
                        qh_addr_q <= cur_f.addr;
                        kind      <= FK_QH_HORIZ;
                        state     <= ST_WAIT;
                    end else begin
                        td_addr  <= cur_f.addr;
                        td_start <= 1'b1;
                        state    <= ST_EXEC;
                    end
                end
                ST_EXEC: if (td_done) begin
                    kind  <= FK_TD_LINK;
                    state <= ST_WAIT;
                end
                ST_WAIT: if (rd_done) begin
                    if (rsp_rsv) begin
                        halted <= 1'b1;
                        irq    <= 1'b1;
                        state  <= ST_HALT;
                    end else begin
                        case (kind)
                            FK_QH_HORIZ: begin
                                horiz_q <= rd_data;
                                kind    <= FK_QH_ELEM;
                            end
                            FK_QH_ELEM: begin
                                cur_link <= rd_data;
                                in_q     <= 1'b1;
                                state    <= ST_DECODE;
                            end
                            default: begin
                                if (in_q && !rsp_depth) begin
                                    cur_link <= horiz_q;
                                    in_q     <= 1'b0;
                                end else begin
                                    cur_link <= rd_data;
                                end
                                state <= ST_DECODE;
                            end
                        endcase
                    end
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sched_link_walker.sv
// Top of the schedule link walker: connects the link decoder, the
// walk sequencer and the single-outstanding read port.
// Assumes the executor raises td_done only after a td_start.
module sched_link_walker
    import sched_walk_pkg::*;
#(
    parameter int QH_ELEM_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [LINK_W-1:0] frame_ptr,
    output logic              mem_rd_req,
    output logic [LINK_W-1:0] mem_rd_addr,
    input  logic [LINK_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              td_start,
    output logic [LINK_W-1:0] td_addr,
    input  logic              td_done,
    output logic              frame_done,
    output logic              halted,
    output logic              irq
);
    logic [LINK_W-1:0] cur_link;
    link_t             cur_f;
    logic              rd_issue;
    logic [LINK_W-1:0] rd_addr;
    logic              rd_done;
    logic [LINK_W-1:0] rd_data;

    sched_link_decode dec_i (
        .word   (cur_link),
        .fields (cur_f)
    );

    sched_walk_ctrl #(.QH_ELEM_OFFSET(QH_ELEM_OFFSET)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_ptr   (frame_ptr),
        .cur_link    (cur_link),
        .cur_f       (cur_f),
        .rd_issue    (rd_issue),
        .rd_addr     (rd_addr),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .td_start    (td_start),
        .td_addr     (td_addr),
        .td_done     (td_done),
        .frame_done  (frame_done),
        .halted      (halted),
        .irq         (irq)
    );

    sched_rd_port rd_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (rd_issue),
        .issue_addr   (rd_addr),
        .done         (rd_done),
        .data         (rd_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_valid (mem_rd_valid)
    );
endmodule

// File: rtl/sched_link_walker_chk.sv
// Port-level protocol checks for sched_link_walker, bound to the top.
// Tracks the outstanding read itself from request and response strobes.
module sched_link_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid,
    input logic        td_start,
    input logic [31:0] td_addr,
    input logic        frame_done,
    input logic        halted,
    input logic        irq
);
    logic outst;

    // Outstanding-read tracker
    always_ff @(posedge clk) begin
        if (!rst_n)            outst <= 1'b0;
        else if (mem_rd_req)   outst <= 1'b1;
        else if (mem_rd_valid) outst <= 1'b0;
    end

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !outst);
    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    // R10
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));
    // R3
    td_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        td_start |-> (td_addr[3:0] == 4'h0));
    // R3
    td_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        td_start |=> !td_start);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && irq));
    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd_req && !td_start && !frame_done && irq));
endmodule

bind sched_link_walker sched_link_walker_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .td_start     (td_start),
    .td_addr      (td_addr),
    .frame_done   (frame_done),
    .halted       (halted),
    .irq          (irq)
);

// File: tb/sched_link_walker_tb_top.sv
// Directed bench for sched_link_walker: a word memory and a TD executor
// model answer the walker; each scenario task checks its own results.
module sched_link_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start;
    logic [31:0] frame_ptr;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        mem_rd_valid;
    logic        td_start;
    logic [31:0] td_addr;
    logic        td_done;
    logic        frame_done;
    logic        halted;
    logic        irq;

    logic [31:0] mem [0:255];
    logic [31:0] td_log [0:15];
    logic [31:0] mem_a;
    int td_cnt, rd_cnt, misalign, early;
    int n_chk, n_bad;
    int mem_lat  = 2;
    int exec_lat = 4;

    always #4 clk = ~clk;

    sched_link_walker dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_ptr(frame_ptr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .td_start(td_start), .td_addr(td_addr), .td_done(td_done),
        .frame_done(frame_done), .halted(halted), .irq(irq)
    );

    // Memory model: one response per request after mem_lat cycles
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_req === 1'b1) begin
                mem_a = mem_rd_addr;
                rd_cnt++;
                if (mem_a[1:0] != 2'b00) misalign++;
                repeat (mem_lat) @(negedge clk);
                mem_rd_data  = mem[mem_a[9:2]];
                mem_rd_valid = 1'b1;
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end
        end
    end

    // Executor model: logs TD addresses, flags reads made before done
    initial begin
        td_done = 1'b0;
        forever begin
            @(negedge clk);
            if (td_start === 1'b1) begin
                if (td_cnt < 16) td_log[td_cnt] = td_addr;
                td_cnt++;
                repeat (exec_lat) begin
                    @(negedge clk);
                    if (mem_rd_req === 1'b1) early++;
                end
                td_done = 1'b1;
                @(negedge clk);
                td_done = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=still running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        frame_start = 1'b0;
        frame_ptr   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h1;
    endtask

    task automatic wr(input int byte_addr, input logic [31:0] val);
        mem[byte_addr[9:2]] = val;
    endtask

    task automatic run_frame(input logic [31:0] ptr, input int extra_at,
                             input logic [31:0] extra_ptr, output bit got_done);
        td_cnt = 0; rd_cnt = 0; misalign = 0; early = 0;
        got_done = 1'b0;
        @(negedge clk);
        frame_start = 1'b1;
        frame_ptr   = ptr;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i == extra_at) begin
                frame_start = 1'b1;
                frame_ptr   = extra_ptr;
            end else begin
                frame_start = 1'b0;
            end
            if (frame_done === 1'b1) begin
                got_done = 1'b1;
                break;
            end
            if (halted === 1'b1) break;
        end
        frame_start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_seq(input string req, input int n, input logic [31:0] e0,
                           input logic [31:0] e1, input logic [31:0] e2);
        chk(req, "td count", 32'(td_cnt), 32'(n));
        if (n > 0 && td_cnt > 0) chk(req, "td[0]", td_log[0], e0);
        if (n > 1 && td_cnt > 1) chk(req, "td[1]", td_log[1], e1);
        if (n > 2 && td_cnt > 2) chk(req, "td[2]", td_log[2], e2);
    endtask

    task automatic t_reset();
        do_reset();
        // R1: all outputs low
        chk("R1", "outputs after reset",
            {27'd0, halted, irq, mem_rd_req, td_start, frame_done}, 32'h0);
    endtask

    task automatic t_flat();
        bit d;
        clear_mem();
        wr(32'h040, 32'h0000_0084);   // -> 0x080, ordering bit set (ignored)
        wr(32'h080, 32'h0000_00C0);
        wr(32'h0C0, 32'h0000_0005);   // terminate, ordering bit set
        run_frame(32'h0000_0040, -1, 32'h0, d);
        // R2 R5: chain walked in order, ordering bit ignored outside a queue
        chk_seq("R5", 3, 32'h40, 32'h80, 32'hC0);
        chk("R5", "frame_done seen", 32'(d), 32'd1);
        // R10: one read per TD link, word aligned
        chk("R10", "read count", 32'(rd_cnt), 32'd3);
        chk("R10", "misaligned reads", 32'(misalign), 32'd0);
        // R3: no read while the executor is busy
        chk("R3", "reads before td_done", 32'(early), 32'd0);
    endtask

    task automatic build_queue(input logic [31:0] first_td_link);
        clear_mem();
        wr(32'h100, 32'h0000_0200);   // QH horizontal -> TD 0x200
        wr(32'h104, 32'h0000_0140);   // QH element -> TD 0x140
        wr(32'h140, first_td_link);
        wr(32'h180, 32'h0000_0005);   // terminate, depth
        wr(32'h200, 32'h0000_0001);
    endtask

    task automatic t_breadth();
        bit d;
        build_queue(32'h0000_0180);   // breadth-first to 0x180
        run_frame(32'h0000_0102, -1, 32'h0, d);
        // R7: breadth leaves the queue after one TD
        chk_seq("R7", 2, 32'h140, 32'h200, 32'h0);
        chk("R7", "frame_done seen", 32'(d), 32'd1);
        // R4: two QH words plus two TD links
        chk("R4", "read count", 32'(rd_cnt), 32'd4);
    endtask

    task automatic t_depth();
        bit d;
        build_queue(32'h0000_0184);   // depth-first to 0x180
        run_frame(32'h0000_0102, -1, 32'h0, d);
        // R8 R6: depth stays in queue, terminate exits via horizontal
        chk_seq("R8", 3, 32'h140, 32'h180, 32'h200);
        chk("R6", "frame_done seen", 32'(d), 32'd1);
        chk("R10", "read count depth", 32'(rd_cnt), 32'd5);
    endtask

    task automatic t_empty_queue();
        bit d;
        clear_mem();
        wr(32'h300, 32'h0000_0200);
        wr(32'h304, 32'h0000_0001);   // empty element
        wr(32'h200, 32'h0000_0001);
        run_frame(32'h0000_0302, -1, 32'h0, d);
        // R6: empty queue goes straight to horizontal
        chk_seq("R6", 1, 32'h200, 32'h0, 32'h0);
        chk("R6", "read count", 32'(rd_cnt), 32'd3);
        run_frame(32'h0000_0001, -1, 32'h0, d);
        // R5: terminating start pointer ends the frame with no reads
        chk("R5", "empty frame done", 32'(d), 32'd1);
        chk("R5", "empty frame reads", 32'(rd_cnt + td_cnt), 32'd0);
    endtask

    task automatic t_restart_ignored();
        bit d;
        clear_mem();
        wr(32'h040, 32'h0000_0080);
        wr(32'h080, 32'h0000_00C0);
        wr(32'h0C0, 32'h0000_0001);
        wr(32'h300, 32'h0000_0200);
        wr(32'h304, 32'h0000_0001);
        run_frame(32'h0000_0040, 6, 32'h0000_0302, d);
        // R11: second strobe during the walk has no effect
        chk_seq("R11", 3, 32'h40, 32'h80, 32'hC0);
        chk("R11", "frame_done seen", 32'(d), 32'd1);
    endtask

    task automatic t_halt_link();
        bit d;
        clear_mem();
        wr(32'h040, 32'h0000_0088);   // reserved bit set
        wr(32'h0C0, 32'h0000_0001);
        run_frame(32'h0000_0040, -1, 32'h0, d);
        // R9: halt after the faulty link, irq raised
        chk_seq("R9", 1, 32'h40, 32'h0, 32'h0);
        chk("R9", "halted/irq/done", {29'd0, halted, irq, d}, 32'h6);
        run_frame(32'h0000_00C0, -1, 32'h0, d);
        // R9: strobe ignored while halted
        chk("R9", "activity while halted", 32'(rd_cnt + td_cnt), 32'd0);
        chk("R9", "still halted", {30'd0, halted, irq}, 32'h3);
        do_reset();
        chk("R9", "cleared by reset", {30'd0, halted, irq}, 32'h0);
    endtask

    task automatic t_halt_ptr();
        bit d;
        clear_mem();
        run_frame(32'h0000_0048, -1, 32'h0, d);
        // R9: faulty start pointer halts before any read
        chk("R9", "ptr halt state", {30'd0, halted, irq}, 32'h3);
        chk("R9", "ptr halt activity", 32'(rd_cnt + td_cnt), 32'd0);
    endtask

    initial begin
        n_chk = 0; n_bad = 0;
        td_cnt = 0; rd_cnt = 0; misalign = 0; early = 0;
        t_reset();
        t_flat();
        t_breadth();
        t_depth();
        t_empty_queue();
        t_restart_ignored();
        t_halt_link();
        t_halt_ptr();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule